// File: doc/BRIEF.md
# Four-Level Interrupt Flag and Enable Banks

This block gathers sixteen interrupt sources into four banks of four and drives one interrupt-level output per bank. Each source is watched for a low-to-high transition; a transition latches a flag bit in that source's bank. A bank's level output stays high for as long as at least one of its flag bits is set and also enabled. The block does no priority encoding between the levels; that is left to whatever consumes the four level lines.

Software reaches the banks through a byte-wide address/data port. Each bank has its own flag register and its own enable register. Flags are cleared by writing ones to them. Enable bits are changed by a write whose top bit chooses between setting and clearing the bits marked in the low nibble. Reads are combinational from the address.

Top module: `irq_level_banks`

## Requirements
- R1: After reset every flag bit and every enable bit is 0, every `irq_lvl_o` bit is 0, and reading any register returns 0x00.
- R2: A source bit (bank b, source s is `src_i[4*b+s]`) that is 0 at one rising clock edge and 1 at the next sets flag bit s of bank b at that second edge. A source held at 1 sets the flag only once: after the flag is cleared it stays clear until the source falls and rises again.
- R3: A write to a bank's flag register clears each flag bit s whose data bit s is 1. Data bits that are 0 leave their flags unchanged.
- R4: A write to a bank's enable register with data bit 7 = 1 sets the enable bits marked by 1s in data bits 3:0. With data bit 7 = 0 it clears those marked bits. Enable bits with a 0 in the data are unchanged in both cases.
- R5: `irq_lvl_o[b]` is 1 exactly when bank b has at least one flag bit that is set and enabled in the same position.
- R6: A flag-register read returns the four flags in bits 3:0, bits 6:4 as 0, and in bit 7 the OR of the flags that are both set and enabled. An enable-register read returns the enables in bits 3:0 and 0 in bits 7:4.
- R7: Bank b (0..3) has its flag register at address 0x100 + 0x10*(b+3) and its enable register 4 bytes above it (0x130/0x134 up to 0x160/0x164). A write to any other address changes nothing, and a read from any other address returns 0x00.
- R8: When a source edge and a write-1 clear reach the same flag bit at the same clock edge, the flag is set after that edge.
- R9: Register writes and source edges of one bank leave the flags, enables and level output of every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 16 | Interrupt sources, bank b in bits 4b+3:4b |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_lvl_o | output | 4 | Interrupt-level output per bank |

## Verification
The assertions take the sources to be synchronous to `clk` and sampled once per edge, so that a single sampled transition counts as one edge; they also assume that a write strobe lasts exactly the cycles in which its effect is wanted. The stimulus changes sources, address and strobe only at falling clock edges and holds each write for one rising edge. It keeps every source low through reset, so that no edge is counted at reset release. Coincident edge-and-clear cases are produced on purpose by changing a source and a flag write on the same falling edge.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  localparam int SRCS     = 4;
  localparam int DW       = 8;
  localparam int SET_BIT  = 7;
  localparam int PEND_BIT = 7;

  typedef logic [SRCS-1:0] src_vec_t;

  // Set/clear update of the enable bits
  function automatic src_vec_t en_update(src_vec_t cur, logic [DW-1:0] wd);
    if (wd[SET_BIT]) return cur | wd[SRCS-1:0];
    else             return cur & ~wd[SRCS-1:0];
  endfunction

  // A new edge wins over a clear of the same bit
  function automatic src_vec_t flag_update(src_vec_t cur, src_vec_t clr, src_vec_t rise);
    return (cur & ~clr) | rise;
  endfunction

  function automatic logic any_pending(src_vec_t f, src_vec_t e);
    return |(f & e);
  endfunction

  function automatic logic [DW-1:0] flag_view(src_vec_t f, logic pend);
    logic [DW-1:0] r;
    r = '0;
    r[SRCS-1:0] = f;
    r[PEND_BIT] = pend;
    return r;
  endfunction

  function automatic logic [DW-1:0] en_view(src_vec_t e);
    logic [DW-1:0] r;
    r = '0;
    r[SRCS-1:0] = e;
    return r;
  endfunction
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode #(
  parameter int ADDR_W     = 12,
  parameter int N_BANKS    = 4,
  parameter int FLAG_BASE  = 'h100,
  parameter int ENA_OFS    = 4,
  parameter int STRIDE     = 'h10,
  parameter int FIRST_SLOT = 3
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  output logic [N_BANKS-1:0] flag_sel_o,
  output logic [N_BANKS-1:0] en_sel_o,
  output logic [N_BANKS-1:0] flag_wr_o,
  output logic [N_BANKS-1:0] en_wr_o
);
  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_BASE + (FIRST_SLOT + b) * STRIDE);
    localparam logic [ADDR_W-1:0] ENA_A  = ADDR_W'(FLAG_BASE + (FIRST_SLOT + b) * STRIDE + ENA_OFS);
    assign flag_sel_o[b] = (addr_i == FLAG_A);
    assign en_sel_o[b]   = (addr_i == ENA_A);
    assign flag_wr_o[b]  = wr_i && flag_sel_o[b];
    assign en_wr_o[b]    = wr_i && en_sel_o[b];
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_lvl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  src_vec_t      rise_i,
  input  logic          flag_wr_i,
  input  logic          en_wr_i,
  input  logic [DW-1:0] wdata_i,
  output src_vec_t      flag_o,
  output src_vec_t      en_o,
  output src_vec_t      clr_o,
  output logic          irq_o
);
  src_vec_t flag_q, en_q;

  assign clr_o = flag_wr_i ? wdata_i[SRCS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= flag_update(flag_q, clr_o, rise_i);
      if (en_wr_i) en_q <= en_update(en_q, wdata_i);
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign irq_o  = any_pending(flag_q, en_q);
endmodule

// File: rtl/irq_level_banks.sv
module irq_level_banks
  import irq_lvl_pkg::*;
#(
  parameter int N_BANKS    = 4,
  parameter int ADDR_W     = 12,
  parameter int FLAG_BASE  = 'h100,
  parameter int ENA_OFS    = 4,
  parameter int STRIDE     = 'h10,
  parameter int FIRST_SLOT = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_BANKS*SRCS-1:0]   src_i,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic [DW-1:0]             bus_wdata,
  output logic [DW-1:0]             bus_rdata,
  output logic [N_BANKS-1:0]        irq_lvl_o
);
  localparam int NSRC = N_BANKS * SRCS;

  // Named internal events, brought out for the checker
  logic [NSRC-1:0]    rise_w;
  logic [NSRC-1:0]    clr_w;
  logic [NSRC-1:0]    flag_w;
  logic [NSRC-1:0]    en_w;
  logic [N_BANKS-1:0] flag_sel_w, en_sel_w, flag_wr_w, en_wr_w;

  irq_edge_det #(.W(NSRC)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (src_i),
    .rise_o (rise_w)
  );

  irq_reg_decode #(
    .ADDR_W(ADDR_W), .N_BANKS(N_BANKS), .FLAG_BASE(FLAG_BASE),
    .ENA_OFS(ENA_OFS), .STRIDE(STRIDE), .FIRST_SLOT(FIRST_SLOT)
  ) u_dec (
    .addr_i     (bus_addr),
    .wr_i       (bus_wr),
    .flag_sel_o (flag_sel_w),
    .en_sel_o   (en_sel_w),
    .flag_wr_o  (flag_wr_w),
    .en_wr_o    (en_wr_w)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    irq_flag_bank u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise_i    (rise_w[b*SRCS +: SRCS]),
      .flag_wr_i (flag_wr_w[b]),
      .en_wr_i   (en_wr_w[b]),
      .wdata_i   (bus_wdata),
      .flag_o    (flag_w[b*SRCS +: SRCS]),
      .en_o      (en_w[b*SRCS +: SRCS]),
      .clr_o     (clr_w[b*SRCS +: SRCS]),
      .irq_o     (irq_lvl_o[b])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < N_BANKS; b++) begin
      if (flag_sel_w[b]) bus_rdata = flag_view(flag_w[b*SRCS +: SRCS], irq_lvl_o[b]);
      if (en_sel_w[b])   bus_rdata = en_view(en_w[b*SRCS +: SRCS]);
    end
  end
endmodule

// File: rtl/irq_level_banks_chk.sv
module irq_level_banks_chk
  import irq_lvl_pkg::*;
#(
  parameter int N_BANKS = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_BANKS*SRCS-1:0] rise_w,
  input logic [N_BANKS*SRCS-1:0] clr_w,
  input logic [N_BANKS*SRCS-1:0] flag_w,
  input logic [N_BANKS*SRCS-1:0] en_w,
  input logic [N_BANKS-1:0]      en_wr_w,
  input logic [N_BANKS-1:0]      irq_lvl_o
);
  for (genvar i = 0; i < N_BANKS*SRCS; i++) begin : g_src
    // R2
    edge_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_w[i] |=> flag_w[i]);
    // R8
    edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_w[i] && clr_w[i]) |=> flag_w[i]);
    // R3
    clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_w[i] && !rise_w[i]) |=> !flag_w[i]);
  end

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    // R4
    en_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_wr_w[b] |=> $stable(en_w[b*SRCS +: SRCS]));
    // R5
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_lvl_o[b] |-> (en_w[b*SRCS +: SRCS] != '0));
    // R5
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_w[b*SRCS +: SRCS] == '0) |-> !irq_lvl_o[b]);
  end
endmodule

bind irq_level_banks irq_level_banks_chk #(.N_BANKS(N_BANKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rise_w    (rise_w),
  .clr_w     (clr_w),
  .flag_w    (flag_w),
  .en_w      (en_w),
  .en_wr_w   (en_wr_w),
  .irq_lvl_o (irq_lvl_o)
);

// File: tb/sim_irq_level_banks.sv
module sim_irq_level_banks;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_i = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [3:0]  irq_lvl_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  irq_level_banks u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lvl_o(irq_lvl_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] fa(int b);
    return 12'(256 + 16 * (b + 3));
  endfunction
  function automatic logic [11:0] ea(int b);
    return 12'(256 + 16 * (b + 3) + 4);
  endfunction
  function automatic logic [7:0] exp_flag(logic [3:0] f, logic [3:0] e);
    return ((f & e) != 4'd0 ? 8'd128 : 8'd0) + {4'd0, f};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    #1 d = bus_rdata;
  endtask

  // raise the given sources of bank b for one edge, then drop them
  task automatic pulse(int b, logic [3:0] pat);
    @(negedge clk);
    src_i[b*NS +: NS] = pat;
    @(posedge clk); #1;
    src_i[b*NS +: NS] = 4'd0;
    @(posedge clk); #1;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", irq_lvl_o, 4'd0);
    for (int b = 0; b < NB; b++) begin
      rd(fa(b), d); check("R1 flag", d, 8'd0);
      rd(ea(b), d); check("R1 enable", d, 8'd0);
    end

    // R2 R5 R6 R9: sweep every enable and flag pattern in every bank
    for (int b = 0; b < NB; b++) begin
      for (int e = 0; e < 16; e++) begin
        for (int f = 0; f < 16; f++) begin
          wr(fa(b), 8'h0F);
          wr(ea(b), 8'h0F);
          wr(ea(b), 8'h80 | 8'(e));
          pulse(b, 4'(f));
          rd(fa(b), d);
          check("R2/R6 flag read", d, exp_flag(4'(f), 4'(e)));
          check("R5/R9 irq", irq_lvl_o, ((f & e) != 0) ? (4'd1 << b) : 4'd0);
          rd(ea(b), d);
          check("R6 enable read", d, 8'(e));
        end
      end
      wr(fa(b), 8'h0F);
      wr(ea(b), 8'h0F);
    end

    // R3 write 0 keeps, write 1 clears
    pulse(1, 4'hF);
    wr(fa(1), 8'h00);
    rd(fa(1), d); check("R3 zero write", d, 8'h0F);
    wr(fa(1), 8'h05);
    rd(fa(1), d); check("R3 partial clear", d, 8'h0A);
    wr(fa(1), 8'h0F);

    // R4 set/clear marked enable bits only
    wr(ea(2), 8'h86);
    rd(ea(2), d); check("R4 set", d, 8'h06);
    wr(ea(2), 8'h89);
    rd(ea(2), d); check("R4 set more", d, 8'h0F);
    wr(ea(2), 8'h05);
    rd(ea(2), d); check("R4 clear", d, 8'h0A);
    wr(ea(2), 8'h0F);

    // R7 unmapped addresses
    pulse(0, 4'h3);
    wr(ea(0), 8'h81);
    wr(12'h120, 8'hFF); wr(12'h170, 8'hFF); wr(12'h131, 8'hFF);
    wr(12'h138, 8'hFF); wr(12'h034, 8'hFF); wr(12'h135, 8'h8F);
    rd(fa(0), d); check("R7 flag kept", d, 8'h83);
    rd(ea(0), d); check("R7 enable kept", d, 8'h01);
    rd(12'h131, d); check("R7 read unmapped", d, 8'h00);
    rd(12'h170, d); check("R7 read unmapped", d, 8'h00);
    rd(12'h234, d); check("R7 read unmapped", d, 8'h00);
    check("R9 irq only bank0", irq_lvl_o, 4'h1);
    wr(fa(0), 8'h0F); wr(ea(0), 8'h0F);

    // R8 edge and clear on the same edge; R2 held level
    pulse(3, 4'h4);
    @(negedge clk);
    src_i[3*NS + 2] = 1'b1;
    bus_addr = fa(3); bus_wdata = 8'h04; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    rd(fa(3), d); check("R8 edge beats clear", d, 8'h04);
    wr(fa(3), 8'h04);
    repeat (3) @(posedge clk);
    rd(fa(3), d); check("R2 held level no reset", d, 8'h00);
    @(negedge clk) src_i[3*NS + 2] = 1'b0;
    pulse(3, 4'h4);
    rd(fa(3), d); check("R2 new edge", d, 8'h04);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule